// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog

This block is a per-core hardware watchdog. Software writes a configuration word that holds a 16-bit period length and a 2-bit escalation mode. From that word the block runs a prescaled down-counter. Software keeps the watchdog quiet by pulsing a poke strobe before each period runs out.

Each period that expires with no poke moves the block one stage up. The first stage raises an interrupt, the second raises a non-maskable interrupt, and the third raises a soft-reset request. The mode sets the highest stage the block may reach, and the block stays in that stage once it gets there. The current counter value can be read at any time on the count output.

The length fills the upper 16 bits of a 24-bit counter, and the lower 8 bits start at zero. The counter steps once every 2**PRE_LOG2 clock cycles. PRE_LOG2 is a build parameter: 8, 9 or 10 gives a divisor of 256, 512 or 1024.

Top module: `wdog_escalate`

## Requirements
- R1: After reset, count is 0, irq, nmi and soft_rst_req are all low, and the block is disabled.
- R2: A configuration write loads count with the length in bits 23:8 and zeros in bits 7:0, so one period is length*256 counter steps.
- R3: While the block is enabled, count drops by one every 2**PRE_LOG2 clock cycles. A configuration write or a poke restarts the prescaler, so the first step comes exactly 2**PRE_LOG2 cycles after that write or poke.
- R4: The edge on which count would step down from 1 is the expiry of a period. On that edge count reloads to length*256, and in mode 1 or higher irq goes high.
- R5: In mode 2 or 3, the expiry of the second period with no poke raises nmi.
- R6: In mode 3, the expiry of the third period with no poke raises soft_rst_req.
- R7: Mode 1 raises only irq, and mode 2 raises irq and then nmi. The block never goes beyond the stage its mode allows, and it holds that stage through later expiries.
- R8: In mode 0, including a configuration word that is all zeros, count does not change and no stage output is raised.
- R9: A length of zero disables the block, whatever the mode: count stays 0 and no stage output is raised.
- R10: A poke reloads count to length*256 and clears irq, nmi and soft_rst_req on the next edge.
- R11: The stage outputs are levels. Once raised, each stays high until a poke or a configuration write. nmi is high only while irq is high, and soft_rst_req is high only while nmi is high.
- R12: A configuration write issued in the middle of an escalation clears all stage outputs, and timing starts again from the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | 16 | Period length, placed in counter bits 23:8 |
| cfg_mode | input | 2 | Escalation mode: 0 off, 1 interrupt, 2 plus NMI, 3 plus soft reset |
| poke | input | 1 | Restart strobe |
| count | output | 24 | Current down-counter value |
| irq | output | 1 | Interrupt stage level |
| nmi | output | 1 | Non-maskable interrupt stage level |
| soft_rst_req | output | 1 | Soft-reset request level |

## Verification
Let E be the edge that samples a configuration write or a poke. The count output shows the reload just after E, and the k-th step appears just after edge E+k*D, where D is 2**PRE_LOG2. Stage s rises just after edge E+s*N*D, where N is length*256. The bench uses a divisor of 4 and drives every input one time unit after a rising edge. It counts edges from the write or poke and samples just before and just after each expected edge, so each step and each stage change is pinned to exactly one cycle.

// File: rtl/wdog_escalate.sv
module wdog_escalate #(
  parameter int PRE_LOG2 = 8,
  parameter int LEN_W    = 16,
  parameter int FRAC_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [LEN_W-1:0]        cfg_len,
  input  logic [1:0]              cfg_mode,
  input  logic                    poke,
  output logic [LEN_W+FRAC_W-1:0] count,
  output logic                    irq,
  output logic                    nmi,
  output logic                    soft_rst_req
);
  localparam int CNT_W = LEN_W + FRAC_W;

  logic [LEN_W-1:0]    len_q;
  logic [1:0]          mode_q;
  logic [1:0]          stage_q;
  logic [PRE_LOG2-1:0] pre_q;
  logic [CNT_W-1:0]    cnt_q;

  logic [CNT_W-1:0] reload;
  logic active, tick, expire;

  assign reload = {len_q, {FRAC_W{1'b0}}};
  assign active = (mode_q != 2'd0) && (len_q != '0);
  assign tick   = active && (&pre_q);
  assign expire = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= '0;
      mode_q  <= '0;
      stage_q <= '0;
      pre_q   <= '0;
      cnt_q   <= '0;
    end else if (cfg_we) begin
      len_q   <= cfg_len;
      mode_q  <= cfg_mode;
      cnt_q   <= {cfg_len, {FRAC_W{1'b0}}};
      pre_q   <= '0;
      stage_q <= '0;
    end else if (poke) begin
      cnt_q   <= reload;
      pre_q   <= '0;
      stage_q <= '0;
    end else if (active) begin
      pre_q <= pre_q + 1'b1;
      if (tick) cnt_q <= expire ? reload : cnt_q - 1'b1;
      if (expire && stage_q < mode_q) stage_q <= stage_q + 2'd1;
    end
  end

  assign count        = cnt_q;
  assign irq          = stage_q >= 2'd1;
  assign nmi          = stage_q >= 2'd2;
  assign soft_rst_req = stage_q == 2'd3;
endmodule

module wdog_escalate_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             poke,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] count,
  input logic             irq,
  input logic             nmi,
  input logic             soft_rst_req
);
  a_r11_nmi_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> irq);
  a_r11_rst_needs_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> nmi);
  a_r10_poke_clears: assert property (@(posedge clk) disable iff (!rst_n)
    poke |=> (!irq && !nmi && !soft_rst_req));
  a_r4_irq_at_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(count) == CNT_W'(1));
  a_r7_mode_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi |-> mode_q >= 2'd2) and (soft_rst_req |-> mode_q == 2'd3));
  a_r8_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && !cfg_we && !poke) |=> ($stable(count) && !irq));
endmodule

bind wdog_escalate wdog_escalate_chk #(.CNT_W(LEN_W + FRAC_W)) chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .poke(poke), .mode_q(mode_q),
  .count(count), .irq(irq), .nmi(nmi), .soft_rst_req(soft_rst_req));

// File: tb/wdog_escalate_test.sv
module wdog_escalate_test;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 2;
  localparam int D  = 1 << PL;

  logic clk = 0, rst_n = 0, cfg_we = 0, poke = 0;
  logic [15:0] cfg_len = 0;
  logic [1:0]  cfg_mode = 0;
  logic [23:0] count;
  logic irq, nmi, soft_rst_req;
  int tests = 0, fails = 0;
  bit done = 0;

  wdog_escalate #(.PRE_LOG2(PL)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_mode(cfg_mode), .poke(poke), .count(count), .irq(irq), .nmi(nmi),
    .soft_rst_req(soft_rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [23:0] c, input logic [2:0] st);
    tests++;
    if (count !== c || {soft_rst_req, nmi, irq} !== st) begin
      fails++;
      $display("FAIL %s: count=%0d outs=%b expected count=%0d outs=%b",
               req, count, {soft_rst_req, nmi, irq}, c, st);
    end
  endtask

  function automatic logic [2:0] lv(input int stage);
    return (stage >= 3) ? 3'b111 : (stage == 2) ? 3'b011 : (stage == 1) ? 3'b001 : 3'b000;
  endfunction

  task automatic cfg(input logic [15:0] l, input logic [1:0] m);
    cfg_len = l; cfg_mode = m; cfg_we = 1;
    step(1);
    cfg_we = 0;
  endtask

  task automatic run_mode(input int l, input int m);
    int n;
    n = l * 256;
    cfg(16'(l), 2'(m));
    chk("R2", 24'(n), 3'b000);
    step(D - 1); chk("R3", 24'(n), 3'b000);
    step(1);     chk("R3", 24'(n - 1), 3'b000);
    step(n*D - D - 1); chk("R4", 24'd1, 3'b000);
    step(1);     chk("R4", 24'(n), lv(m >= 1 ? 1 : 0));
    step(n*D);   chk("R5", 24'(n), lv(m >= 2 ? 2 : m));
    step(n*D);   chk("R6", 24'(n), lv(m >= 3 ? 3 : m));
    step(n*D);   chk("R7", 24'(n), lv(m));
    step(n*D/2); chk("R11", 24'(n - n/2), lv(m));
  endtask

  initial begin
    step(3);
    chk("R1", 24'd0, 3'b000);
    rst_n = 1;
    step(20);
    chk("R1", 24'd0, 3'b000);

    for (int l = 1; l <= 2; l++) run_mode(l, 3);
    run_mode(1, 1);
    run_mode(1, 2);

    // R10: poke after escalation
    run_mode(1, 3);
    poke = 1; step(1); poke = 0;
    chk("R10", 24'd256, 3'b000);
    step(D - 1); chk("R10", 24'd256, 3'b000);
    step(1);     chk("R10", 24'd255, 3'b000);
    step(256*D - D - 1); chk("R10", 24'd1, 3'b000);
    step(1);     chk("R10", 24'd256, 3'b001);

    // R12: config write mid-escalation
    step(256*D); chk("R12", 24'd256, 3'b011);
    cfg(16'd2, 2'd3);
    chk("R12", 24'd512, 3'b000);
    step(512*D - 1); chk("R12", 24'd1, 3'b000);
    step(1);         chk("R12", 24'd512, 3'b001);

    // R8: mode 0 with length, and all-zero word
    cfg(16'd5, 2'd0);
    step(3000); chk("R8", 24'd1280, 3'b000);
    cfg(16'd0, 2'd0);
    step(100); chk("R8", 24'd0, 3'b000);

    // R9: zero length, full mode
    cfg(16'd0, 2'd3);
    step(4000); chk("R9", 24'd0, 3'b000);
    poke = 1; step(1); poke = 0;
    step(100); chk("R9", 24'd0, 3'b000);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * CLK_PERIOD);
        tests++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule